// File: doc/BRIEF.md
# Tagged Packet Stream Mux/Demux

This block sits between a single bidirectional packet stream and two pairs of streams, one pair carrying replies and one carrying requests. Every stream moves 128-bit beats under a valid/ready/last handshake, and the first beat of each packet is a 128-bit header. In the merge direction, packets from a reply input and a request input are joined onto one merged output. Replies are marked by forcing header bit 95 to 1, and replies win when both inputs are waiting. In the split direction, packets from one merged input are steered whole to a reply output or a request output, according to header bit 95 of their first beat.

The two directions share no state, so either one can stall without holding up the other. A compile-time option places a two-entry skid register on every output. This adds exactly one cycle of latency, keeps one beat per cycle, and leaves no combinational path from an output ready to an input ready. With the option off, the outputs are combinational.

Top module: `pkt_tag_mux`

## Requirements
- R1: A packet taken from the reply input leaves on the merged output with header bit 95 set to 1. Every other header bit, and every bit of its later beats including bit 95, is unchanged.
- R2: A packet taken from the request input leaves on the merged output bit for bit unchanged, including header bit 95 whether it is 0 or 1.
- R3: On the split path, a header with bit 95 = 1 sends the whole packet (header to last beat) to the reply output, and bit 95 = 0 sends it to the request output. All beats are passed unchanged.
- R4: When the merge arbiter is at a packet boundary and both inputs are valid, the reply input is granted.
- R5: Once a merge source has offered a beat, it keeps the merged output until its last beat is accepted. Packets never interleave, and at most one merge input sees ready in a cycle.
- R6: While an output has valid high and ready low, its valid, data and last stay stable. No beat is lost or duplicated under any pattern of valid gaps and backpressure.
- R7: A stalled merged output does not stop the split path, and stalled split outputs do not stop the merge path.
- R8: With REG_OUT=1, a beat accepted at an input appears at the output one clock later. A back-to-back packet moves at one beat per clock.
- R9: Reset is synchronous and active high. With REG_OUT=1, all three output valids are 0 in the cycle after reset is sampled, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpl_in_valid | input | 1 | Reply input beat valid |
| rpl_in_ready | output | 1 | Reply input beat accepted |
| rpl_in_data | input | 128 | Reply input beat |
| rpl_in_last | input | 1 | Reply input last beat of packet |
| req_in_valid | input | 1 | Request input beat valid |
| req_in_ready | output | 1 | Request input beat accepted |
| req_in_data | input | 128 | Request input beat |
| req_in_last | input | 1 | Request input last beat of packet |
| mo_valid | output | 1 | Merged output beat valid |
| mo_ready | input | 1 | Merged output beat accepted |
| mo_data | output | 128 | Merged output beat |
| mo_last | output | 1 | Merged output last beat |
| mi_valid | input | 1 | Merged input beat valid |
| mi_ready | output | 1 | Merged input beat accepted |
| mi_data | input | 128 | Merged input beat |
| mi_last | input | 1 | Merged input last beat |
| rplo_valid | output | 1 | Reply output beat valid |
| rplo_ready | input | 1 | Reply output beat accepted |
| rplo_data | output | 128 | Reply output beat |
| rplo_last | output | 1 | Reply output last beat |
| reqo_valid | output | 1 | Request output beat valid |
| reqo_ready | input | 1 | Request output beat accepted |
| reqo_data | output | 128 | Request output beat |
| reqo_last | output | 1 | Request output last beat |

## Verification
The bench builds the block with its default 128-bit beats, tag bit 95 and REG_OUT=1. That setting brings the skid registers, the one-cycle latency and the stall-while-full cases within reach.

Packet lengths 1 to 4 are swept against three handshake patterns: always on, random backpressure, and random valid gaps combined with backpressure. Tag values of 0 and 1 are driven on headers and on data beats alike. Every beat is compared with a per-source expected queue, so a wrong tag, a misroute, an interleave, a loss or a duplicate each shows up as a mismatch. Directed runs then pin down arbitration order, independence of the two directions, and exact latency and throughput.

// File: rtl/pkt_tag_mux_pkg.sv
package pkt_tag_mux_pkg;
    localparam int unsigned DEF_DATA_W  = 128;
    localparam int unsigned DEF_TAG_BIT = 95;

    typedef enum logic {
        SRC_REQ = 1'b0,
        SRC_RPL = 1'b1
    } src_e;
endpackage

// File: rtl/ptm_oreg.sv
module ptm_oreg #(
    parameter int unsigned W  = 128,
    parameter bit          EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_last,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         out_last
);
    generate
        if (EN) begin : g_reg
            typedef struct packed {
                logic         m_v;
                logic         m_l;
                logic [W-1:0] m_d;
                logic         s_v;
                logic         s_l;
                logic [W-1:0] s_d;
            } skid_t;

            skid_t st_d, st_q;

            always_comb begin
                st_d     = st_q;
                in_ready = !st_q.s_v;
                if (!st_q.m_v || out_ready) begin
                    if (st_q.s_v) begin
                        st_d.m_v = 1'b1;
                        st_d.m_l = st_q.s_l;
                        st_d.m_d = st_q.s_d;
                        st_d.s_v = 1'b0;
                    end else begin
                        st_d.m_v = in_valid;
                        st_d.m_l = in_last;
                        st_d.m_d = in_data;
                    end
                end else if (in_valid && !st_q.s_v) begin
                    st_d.s_v = 1'b1;
                    st_d.s_l = in_last;
                    st_d.s_d = in_data;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign out_valid = st_q.m_v;
            assign out_data  = st_q.m_d;
            assign out_last  = st_q.m_l;
        end else begin : g_thru
            logic unused_thru;
            assign unused_thru = clk ^ rst;
            assign in_ready    = out_ready;
            assign out_valid   = in_valid;
            assign out_data    = in_data;
            assign out_last    = in_last;
        end
    endgenerate
endmodule

// File: rtl/ptm_merge.sv
module ptm_merge
    import pkt_tag_mux_pkg::*;
#(
    parameter int unsigned W   = DEF_DATA_W,
    parameter int unsigned TAG = DEF_TAG_BIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rpl_valid,
    output logic         rpl_ready,
    input  logic [W-1:0] rpl_data,
    input  logic         rpl_last,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [W-1:0] req_data,
    input  logic         req_last,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         out_last
);
    typedef struct packed {
        logic hdr;
        logic lock;
        src_e src;
    } mst_t;

    mst_t st_d, st_q;
    src_e sel;

    always_comb begin
        st_d = st_q;
        sel  = st_q.lock ? st_q.src : (rpl_valid ? SRC_RPL : SRC_REQ);
        if (sel == SRC_RPL) begin
            out_valid = rpl_valid;
            out_data  = rpl_data;
            out_last  = rpl_last;
            if (st_q.hdr) begin
                out_data[TAG] = 1'b1;
            end
        end else begin
            out_valid = req_valid;
            out_data  = req_data;
            out_last  = req_last;
        end
        rpl_ready = (sel == SRC_RPL) && out_ready;
        req_ready = (sel == SRC_REQ) && out_ready;
        if (out_valid) begin
            st_d.lock = 1'b1;
            st_d.src  = sel;
            if (out_ready) begin
                st_d.hdr  = out_last;
                st_d.lock = !out_last;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{hdr: 1'b1, lock: 1'b0, src: SRC_REQ};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ptm_split.sv
module ptm_split
    import pkt_tag_mux_pkg::*;
#(
    parameter int unsigned W   = DEF_DATA_W,
    parameter int unsigned TAG = DEF_TAG_BIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_last,
    output logic         rpl_valid,
    input  logic         rpl_ready,
    output logic         req_valid,
    input  logic         req_ready,
    output logic [W-1:0] out_data,
    output logic         out_last
);
    typedef struct packed {
        logic hdr;
        src_e route;
    } sst_t;

    sst_t st_d, st_q;
    src_e route;

    always_comb begin
        st_d      = st_q;
        route     = st_q.hdr ? src_e'(in_data[TAG]) : st_q.route;
        rpl_valid = in_valid && (route == SRC_RPL);
        req_valid = in_valid && (route == SRC_REQ);
        in_ready  = (route == SRC_RPL) ? rpl_ready : req_ready;
        out_data  = in_data;
        out_last  = in_last;
        if (in_valid && in_ready) begin
            st_d.hdr   = in_last;
            st_d.route = route;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{hdr: 1'b1, route: SRC_REQ};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pkt_tag_mux.sv
module pkt_tag_mux
    import pkt_tag_mux_pkg::*;
#(
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned TAG_BIT = DEF_TAG_BIT,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rpl_in_valid,
    output logic              rpl_in_ready,
    input  logic [DATA_W-1:0] rpl_in_data,
    input  logic              rpl_in_last,
    input  logic              req_in_valid,
    output logic              req_in_ready,
    input  logic [DATA_W-1:0] req_in_data,
    input  logic              req_in_last,
    output logic              mo_valid,
    input  logic              mo_ready,
    output logic [DATA_W-1:0] mo_data,
    output logic              mo_last,
    input  logic              mi_valid,
    output logic              mi_ready,
    input  logic [DATA_W-1:0] mi_data,
    input  logic              mi_last,
    output logic              rplo_valid,
    input  logic              rplo_ready,
    output logic [DATA_W-1:0] rplo_data,
    output logic              rplo_last,
    output logic              reqo_valid,
    input  logic              reqo_ready,
    output logic [DATA_W-1:0] reqo_data,
    output logic              reqo_last
);
    localparam int unsigned NSPLIT = 2;

    // merge path
    logic              mg_valid, mg_ready, mg_last;
    logic [DATA_W-1:0] mg_data;

    ptm_merge #(.W(DATA_W), .TAG(TAG_BIT)) u_merge (
        .clk      (clk),
        .rst      (rst),
        .rpl_valid(rpl_in_valid),
        .rpl_ready(rpl_in_ready),
        .rpl_data (rpl_in_data),
        .rpl_last (rpl_in_last),
        .req_valid(req_in_valid),
        .req_ready(req_in_ready),
        .req_data (req_in_data),
        .req_last (req_in_last),
        .out_valid(mg_valid),
        .out_ready(mg_ready),
        .out_data (mg_data),
        .out_last (mg_last)
    );

    ptm_oreg #(.W(DATA_W), .EN(REG_OUT)) u_mo_reg (
        .clk      (clk),
        .rst      (rst),
        .in_valid (mg_valid),
        .in_ready (mg_ready),
        .in_data  (mg_data),
        .in_last  (mg_last),
        .out_valid(mo_valid),
        .out_ready(mo_ready),
        .out_data (mo_data),
        .out_last (mo_last)
    );

    // split path: index 0 = request side, 1 = reply side
    logic              sp_valid [NSPLIT];
    logic              sp_ready [NSPLIT];
    logic              so_valid [NSPLIT];
    logic              so_ready [NSPLIT];
    logic [DATA_W-1:0] so_data  [NSPLIT];
    logic              so_last  [NSPLIT];
    logic [DATA_W-1:0] sp_data;
    logic              sp_last;

    ptm_split #(.W(DATA_W), .TAG(TAG_BIT)) u_split (
        .clk      (clk),
        .rst      (rst),
        .in_valid (mi_valid),
        .in_ready (mi_ready),
        .in_data  (mi_data),
        .in_last  (mi_last),
        .rpl_valid(sp_valid[1]),
        .rpl_ready(sp_ready[1]),
        .req_valid(sp_valid[0]),
        .req_ready(sp_ready[0]),
        .out_data (sp_data),
        .out_last (sp_last)
    );

    generate
        for (genvar i = 0; i < NSPLIT; i++) begin : g_so
            ptm_oreg #(.W(DATA_W), .EN(REG_OUT)) u_reg (
                .clk      (clk),
                .rst      (rst),
                .in_valid (sp_valid[i]),
                .in_ready (sp_ready[i]),
                .in_data  (sp_data),
                .in_last  (sp_last),
                .out_valid(so_valid[i]),
                .out_ready(so_ready[i]),
                .out_data (so_data[i]),
                .out_last (so_last[i])
            );
        end
    endgenerate

    assign so_ready[0] = reqo_ready;
    assign so_ready[1] = rplo_ready;
    assign reqo_valid  = so_valid[0];
    assign reqo_data   = so_data[0];
    assign reqo_last   = so_last[0];
    assign rplo_valid  = so_valid[1];
    assign rplo_data   = so_data[1];
    assign rplo_last   = so_last[1];
endmodule

// File: rtl/ptm_chk.sv
module ptm_chk #(
    parameter int unsigned DATA_W  = 128,
    parameter int unsigned TAG_BIT = 95,
    parameter bit          REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              rpl_in_ready,
    input logic              req_in_ready,
    input logic              mo_valid,
    input logic              mo_ready,
    input logic [DATA_W-1:0] mo_data,
    input logic              mo_last,
    input logic              rplo_valid,
    input logic              rplo_ready,
    input logic [DATA_W-1:0] rplo_data,
    input logic              rplo_last,
    input logic              reqo_valid,
    input logic              reqo_ready,
    input logic [DATA_W-1:0] reqo_data,
    input logic              reqo_last
);
    logic rplo_hdr, reqo_hdr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rplo_hdr <= 1'b1;
            reqo_hdr <= 1'b1;
        end else begin
            if (rplo_valid && rplo_ready) rplo_hdr <= rplo_last;
            if (reqo_valid && reqo_ready) reqo_hdr <= reqo_last;
        end
    end

    AST_MO_HOLD: assert property (@(posedge clk) disable iff (rst)
        mo_valid && !mo_ready |=> mo_valid && $stable(mo_data) && $stable(mo_last)); // R6
    AST_RPLO_HOLD: assert property (@(posedge clk) disable iff (rst)
        rplo_valid && !rplo_ready |=> rplo_valid && $stable(rplo_data) && $stable(rplo_last)); // R6
    AST_REQO_HOLD: assert property (@(posedge clk) disable iff (rst)
        reqo_valid && !reqo_ready |=> reqo_valid && $stable(reqo_data) && $stable(reqo_last)); // R6
    AST_RPLO_TAG: assert property (@(posedge clk) disable iff (rst)
        rplo_valid && rplo_hdr |-> rplo_data[TAG_BIT]); // R3
    AST_REQO_TAG: assert property (@(posedge clk) disable iff (rst)
        reqo_valid && reqo_hdr |-> !reqo_data[TAG_BIT]); // R3
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        !(rpl_in_ready && req_in_ready)); // R5

    generate
        if (REG_OUT) begin : g_rst
            AST_RST_IDLE: assert property (@(posedge clk)
                rst |=> !mo_valid && !rplo_valid && !reqo_valid); // R9
        end
    endgenerate
endmodule

bind pkt_tag_mux ptm_chk #(.DATA_W(DATA_W), .TAG_BIT(TAG_BIT), .REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rpl_in_ready(rpl_in_ready),
    .req_in_ready(req_in_ready),
    .mo_valid    (mo_valid),
    .mo_ready    (mo_ready),
    .mo_data     (mo_data),
    .mo_last     (mo_last),
    .rplo_valid  (rplo_valid),
    .rplo_ready  (rplo_ready),
    .rplo_data   (rplo_data),
    .rplo_last   (rplo_last),
    .reqo_valid  (reqo_valid),
    .reqo_ready  (reqo_ready),
    .reqo_data   (reqo_data),
    .reqo_last   (reqo_last)
);

// File: tb/sim_pkt_tag_mux.sv
module sim_pkt_tag_mux;
    localparam int W   = 128;
    localparam int TAG = 95;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic         rpl_in_valid = 0, rpl_in_ready, rpl_in_last = 0;
    logic [W-1:0] rpl_in_data = '0;
    logic         req_in_valid = 0, req_in_ready, req_in_last = 0;
    logic [W-1:0] req_in_data = '0;
    logic         mo_valid, mo_ready = 0, mo_last;
    logic [W-1:0] mo_data;
    logic         mi_valid = 0, mi_ready, mi_last = 0;
    logic [W-1:0] mi_data = '0;
    logic         rplo_valid, rplo_ready = 0, rplo_last;
    logic [W-1:0] rplo_data;
    logic         reqo_valid, reqo_ready = 0, reqo_last;
    logic [W-1:0] reqo_data;

    pkt_tag_mux #(.DATA_W(W), .TAG_BIT(TAG), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst),
        .rpl_in_valid(rpl_in_valid), .rpl_in_ready(rpl_in_ready), .rpl_in_data(rpl_in_data), .rpl_in_last(rpl_in_last),
        .req_in_valid(req_in_valid), .req_in_ready(req_in_ready), .req_in_data(req_in_data), .req_in_last(req_in_last),
        .mo_valid(mo_valid), .mo_ready(mo_ready), .mo_data(mo_data), .mo_last(mo_last),
        .mi_valid(mi_valid), .mi_ready(mi_ready), .mi_data(mi_data), .mi_last(mi_last),
        .rplo_valid(rplo_valid), .rplo_ready(rplo_ready), .rplo_data(rplo_data), .rplo_last(rplo_last),
        .reqo_valid(reqo_valid), .reqo_ready(reqo_ready), .reqo_data(reqo_data), .reqo_last(reqo_last)
    );

    typedef struct packed {
        logic [W-1:0] d;
        logic         l;
    } beat_t;

    beat_t q_rpl[$], q_req[$], q_mi[$];
    beat_t e_mo_rpl[$], e_mo_req[$], e_rplo[$], e_reqo[$];
    int    hdr_log[$];
    int    t_in[$], t_out[$];

    int          checks = 0, fails = 0, cyc = 0, mode = 0, next_id = 1;
    bit          done = 0, rec = 0, stall_mo = 0, stall_sp = 0;
    bit          h_rpl = 0, h_req = 0, h_mi = 0, mo_hdr = 1, mo_cur = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string what, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %h exp %h", what, act, exp);
        end
    endtask

    // data fields: [7:0] beat, [15:8] id, [16] source (1 = reply), TAG bit chosen by caller
    function automatic logic [W-1:0] mk(input int src, input int id, input int b, input bit tagv);
        logic [W-1:0] d;
        d          = '0;
        d[7:0]     = b[7:0];
        d[15:8]    = id[7:0];
        d[16]      = src[0];
        d[63:32]   = 32'h5A5A_0000 ^ {id[15:0], b[15:0]};
        d[127:96]  = {id[7:0], b[7:0], 16'h3C96};
        d[TAG]     = tagv;
        return d;
    endfunction

    task automatic add_merge(input int src, input int len);
        int id = next_id++;
        for (int b = 0; b < len; b++) begin
            beat_t bt, ex;
            bt.d = mk(src, id, b, (b == 0) ? id[0] : (b[0] ^ id[1]));
            bt.l = (b == len - 1);
            ex   = bt;
            if (src == 1 && b == 0) ex.d[TAG] = 1'b1;
            if (src == 1) begin q_rpl.push_back(bt); e_mo_rpl.push_back(ex); end
            else          begin q_req.push_back(bt); e_mo_req.push_back(ex); end
        end
    endtask

    task automatic add_split(input int len, input bit route);
        int id = next_id++;
        for (int b = 0; b < len; b++) begin
            beat_t bt;
            bt.d = mk(2, id, b, (b == 0) ? route : (b[0] ^ id[0]));
            bt.l = (b == len - 1);
            q_mi.push_back(bt);
            if (route) e_rplo.push_back(bt);
            else       e_reqo.push_back(bt);
        end
    endtask

    task automatic take(ref beat_t q[$], input beat_t g, input string what);
        if (q.size() == 0) begin
            chk(1'b0, {what, " unexpected beat"}, {g.d, g.l}, '0);
        end else begin
            chk(g == q[0], what, {g.d, g.l}, {q[0].d, q[0].l});
            void'(q.pop_front());
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!h_rpl) rpl_in_valid = (q_rpl.size() > 0) && (mode < 2 || lfsr[0]);
        if (rpl_in_valid) {rpl_in_data, rpl_in_last} = q_rpl[0];
        if (!h_req) req_in_valid = (q_req.size() > 0) && (mode < 2 || lfsr[1]);
        if (req_in_valid) {req_in_data, req_in_last} = q_req[0];
        if (!h_mi) mi_valid = (q_mi.size() > 0) && (mode < 2 || lfsr[2]);
        if (mi_valid) {mi_data, mi_last} = q_mi[0];
        mo_ready   = !stall_mo && (mode == 0 || lfsr[3]);
        rplo_ready = !stall_sp && (mode == 0 || lfsr[4]);
        reqo_ready = !stall_sp && (mode == 0 || lfsr[5]);
        #1;
        h_rpl = rpl_in_valid && !rpl_in_ready;
        if (rpl_in_valid && rpl_in_ready) void'(q_rpl.pop_front());
        h_req = req_in_valid && !req_in_ready;
        if (req_in_valid && req_in_ready) begin
            void'(q_req.pop_front());
            if (rec) t_in.push_back(cyc);
        end
        h_mi = mi_valid && !mi_ready;
        if (mi_valid && mi_ready) void'(q_mi.pop_front());
        if (mo_valid && mo_ready) begin
            if (rec) t_out.push_back(cyc);
            if (mo_hdr) begin
                mo_cur = mo_data[16];
                hdr_log.push_back(int'(mo_data[16]));
            end
            if (mo_cur) take(e_mo_rpl, {mo_data, mo_last}, "R1 R5 merged reply beat");
            else        take(e_mo_req, {mo_data, mo_last}, "R2 R5 merged request beat");
            mo_hdr = mo_last;
        end
        if (rplo_valid && rplo_ready) take(e_rplo, {rplo_data, rplo_last}, "R3 reply output beat");
        if (reqo_valid && reqo_ready) take(e_reqo, {reqo_data, reqo_last}, "R3 request output beat");
    endtask

    task automatic drain();
        int n = 0;
        while ((e_mo_rpl.size() + e_mo_req.size() + e_rplo.size() + e_reqo.size()) != 0 && n < 3000) begin
            step();
            n++;
        end
        chk(e_mo_rpl.size() == 0 && e_mo_req.size() == 0, "R6 merged beats outstanding",
            e_mo_rpl.size() + e_mo_req.size(), 0);
        chk(e_rplo.size() == 0 && e_reqo.size() == 0, "R6 split beats outstanding",
            e_rplo.size() + e_reqo.size(), 0);
    endtask

    initial begin
        // R9: reset with all inputs busy
        rst = 1'b1;
        @(negedge clk);
        rpl_in_valid = 1; req_in_valid = 1; mi_valid = 1;
        mo_ready = 1; rplo_ready = 1; reqo_ready = 1;
        repeat (3) @(negedge clk);
        #1;
        chk(!mo_valid, "R9 mo_valid in reset", mo_valid, 0);
        chk(!rplo_valid, "R9 rplo_valid in reset", rplo_valid, 0);
        chk(!reqo_valid, "R9 reqo_valid in reset", reqo_valid, 0);
        rpl_in_valid = 0; req_in_valid = 0; mi_valid = 0;
        @(negedge clk);
        rst = 1'b0;

        // R8: latency and throughput on an 8-beat request packet
        mode = 0;
        rec  = 1;
        add_merge(0, 8);
        drain();
        rec = 0;
        chk(t_in.size() == 8 && t_out.size() == 8, "R8 beat count", t_in.size(), 8);
        for (int i = 0; i < 8 && i < t_in.size() && i < t_out.size(); i++) begin
            chk(t_out[i] == t_in[i] + 1, "R8 latency", t_out[i] - t_in[i], 1);
            chk(t_in[i] == t_in[0] + i, "R8 throughput", t_in[i] - t_in[0], i);
        end

        // R4: both inputs pending at a boundary; expected order reply, reply, request
        hdr_log.delete();
        stall_mo = 1;
        add_merge(1, 2);
        add_merge(1, 1);
        add_merge(0, 2);
        repeat (6) step();
        stall_mo = 0;
        drain();
        chk(hdr_log.size() == 3, "R4 packet count", hdr_log.size(), 3);
        if (hdr_log.size() == 3) begin
            chk(hdr_log[0] == 1, "R4 first grant", hdr_log[0], 1);
            chk(hdr_log[1] == 1, "R4 second grant", hdr_log[1], 1);
            chk(hdr_log[2] == 0, "R4 third grant", hdr_log[2], 0);
        end

        // R7: merged output stalled, split path must still deliver
        stall_mo = 1;
        add_merge(1, 3);
        add_split(3, 1);
        add_split(2, 0);
        add_split(1, 1);
        repeat (30) step();
        chk(e_rplo.size() == 0 && e_reqo.size() == 0, "R7 split blocked by merge stall",
            e_rplo.size() + e_reqo.size(), 0);
        chk(e_mo_rpl.size() != 0, "R7 merge stall not held", e_mo_rpl.size(), 1);
        stall_mo = 0;
        drain();
        // R7: split outputs stalled, merge path must still deliver
        stall_sp = 1;
        add_split(2, 0);
        add_merge(0, 2);
        add_merge(1, 3);
        repeat (30) step();
        chk(e_mo_rpl.size() == 0 && e_mo_req.size() == 0, "R7 merge blocked by split stall",
            e_mo_rpl.size() + e_mo_req.size(), 0);
        chk(e_reqo.size() != 0, "R7 split stall not held", e_reqo.size(), 1);
        stall_sp = 0;
        drain();

        // R1 R2 R3 R5 R6: sweep handshake pattern and packet length
        for (int m = 0; m < 3; m++) begin
            mode = m;
            for (int len = 1; len <= 4; len++) begin
                for (int k = 0; k < 4; k++) begin
                    add_merge(1, len);
                    add_merge(0, 5 - len);
                    add_split(len, k[0]);
                    add_split(5 - len, !k[1]);
                end
            end
            drain();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule